// File: doc/BRIEF.md
# Delta-Sigma Converter Configuration and Sequencing Control

This block is the digital control side of a single-channel delta-sigma converter. A host reads and writes one 8-bit configuration byte that selects free-running or single-shot operation, a rate code that fixes both the conversion time and the result resolution, and a front-end gain. The block times every conversion from the rate code, waits for the converter's done strobe, and latches the converter word, sign-extended from the selected resolution to the full result width.

Bit 7 of the byte is a freshness flag with two meanings. On read it shows whether an unread result is waiting. On write it is a trigger, and it acts only in single-shot mode. In single-shot mode the block drops into standby once its one conversion is latched. Any host access wakes it. A configuration write may arrive at any time. It abandons the conversion in flight and restarts timing under the new settings.

Top module: `adc_cfg_ctrl`

## Requirements
- R1: Reset state and first conversion. After synchronous reset the configuration byte reads 0x90 and `standby` is 0. In free-running mode a `conv_start` pulse appears in the first cycle after reset is released.
- R2: Byte layout. Bit 7 reads 1 when no unread result is held and 0 when one is held. Bits 6:5 are channel bits that read back as written and change nothing. Bit 4 is the mode: 1 means free-running and 0 means single-shot. Bits 3:2 are the rate code. Bits 1:0 are the gain code.
- R3: Result latch. When a result is latched, bit 7 reads 0. `result_rdata` holds the low bits of `conv_data`, sign-extended to 18 bits. The number of low bits is 12, 14, 16 or 18 for rate codes 0, 1, 2 and 3.
- R4: A `host_rd` pulse sets bit 7 back to 1 in the next cycle, unless a result is latched in the same cycle.
- R5: Timing. A conversion counts BASE_TICKS×4^rate cycles, then latches on the next cycle in which `conv_done` is high. With `conv_done` held high, a result appears BASE_TICKS×4^rate+1 cycles after the starting write. In free-running mode `conv_start` pulses repeat at that spacing.
- R6: Single-shot trigger. In single-shot mode a write with bit 7 = 1 raises `conv_start` in the next cycle and starts one conversion. A write with bit 7 = 0 starts nothing.
- R7: In free-running mode bit 7 of a write has no effect. Every write with bit 4 = 1 restarts conversions, whether bit 7 is 0 or 1.
- R8: After a write, `gain_sel` equals bits 1:0 of the written byte.
- R9: Standby. Once a single-shot conversion is latched, `standby` is 1. A host read or write clears it. In free-running mode `standby` stays 0.
- R10: A write during a conversion abandons it. Only the restarted conversion produces a result, timed from that write.
- R11: Done wait. Until `conv_done` is high, no result is latched after the count expires. The result latches on the first cycle `conv_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle configuration write strobe |
| host_wdata | input | 8 | Configuration byte to write |
| host_rd | input | 1 | One-cycle read strobe, marks the result as consumed |
| cfg_rdata | output | 8 | Configuration byte with freshness flag in bit 7 |
| result_rdata | output | RES_W | Last latched result, sign-extended |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | RES_W | Converter output word |
| conv_start | output | 1 | One-cycle pulse when a conversion begins |
| gain_sel | output | 2 | Gain code to the analog front end |
| standby | output | 1 | Low-power standby indicator |

## Verification
The assertions assume that `host_wr` and `host_rd` are single-cycle strobes sampled only on clock edges. They also assume that `conv_done` and `conv_data` are stable around the edge that samples them. The bench drives all of these inputs on falling edges, so each strobe covers exactly one rising edge. It holds `conv_done` high except in the done-wait scenario. The bench always reads out a result before triggering the next one, so every expected result shows up as a fresh falling edge of the flag.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0] chan;
    logic       cont;
    logic [1:0] rate;
    logic [1:0] gain;
  } cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h90;

  // Resolution in bits selected by a rate code.
  function automatic int res_bits(input logic [1:0] rate);
    return 12 + 2 * int'(rate);
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o,
  output logic [1:0] gain_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.chan <= CFG_RESET[6:5];
      cfg_q.cont <= CFG_RESET[4];
      cfg_q.rate <= CFG_RESET[3:2];
      cfg_q.gain <= CFG_RESET[1:0];
    end else if (wr_i) begin
      cfg_q.chan <= wdata_i[6:5];
      cfg_q.cont <= wdata_i[4];
      cfg_q.rate <= wdata_i[3:2];
      cfg_q.gain <= wdata_i[1:0];
    end
  end

  assign cfg_o  = cfg_q;
  assign gain_o = cfg_q.gain;

  AST_GAIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (gain_o == $past(wdata_i[1:0]))); // R8

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int BASE_TICKS = 4,
  parameter int CNT_W      = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic       stop_i,
  input  logic [1:0] rate_i,
  output logic       zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [CNT_W-1:0] period;

  // Base period scaled by 4 per rate step: 1, 4, 16, 64 units.
  always_comb begin
    period = CNT_W'(BASE_TICKS) << {rate_i, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= period - CNT_W'(1);
      active_q <= 1'b1;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  assign zero_o = active_q && (cnt_q == '0);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_cfg_pkg::*;
#(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             wr_trig_i,
  input  logic             wr_cont_i,
  input  logic [1:0]       wr_rate_i,
  input  logic             rd_i,
  input  cfg_t             cfg_i,
  input  logic             tmr_zero_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             tmr_load_o,
  output logic             tmr_stop_o,
  output logic [1:0]       tmr_rate_o,
  output logic             conv_start_o,
  output logic             standby_o,
  output logic             fresh_o,
  output logic [RES_W-1:0] result_o
);

  seq_state_e st_q;
  logic wr_start, idle_kick, latch, relaunch;

  function automatic logic [RES_W-1:0] sext(input logic [RES_W-1:0] d,
                                            input logic [1:0] r);
    int w;
    logic [RES_W-1:0] o;
    w = res_bits(r);
    if (w > RES_W) w = RES_W;
    for (int i = 0; i < RES_W; i++) o[i] = (i < w) ? d[i] : d[w-1];
    return o;
  endfunction

  always_comb begin
    wr_start   = wr_i && (wr_cont_i || wr_trig_i);
    idle_kick  = !wr_i && (st_q == ST_IDLE) && cfg_i.cont;
    latch      = !wr_i && (st_q == ST_WAIT) && conv_done_i;
    relaunch   = latch && cfg_i.cont;
    tmr_load_o = wr_start || idle_kick || relaunch;
    tmr_stop_o = wr_i && !wr_start;
    tmr_rate_o = wr_i ? wr_rate_i : cfg_i.rate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
    end else if (wr_i) begin
      st_q <= wr_start ? ST_RUN : ST_IDLE;
    end else if (idle_kick) begin
      st_q <= ST_RUN;
    end else if ((st_q == ST_RUN) && tmr_zero_i) begin
      st_q <= ST_WAIT;
    end else if (latch) begin
      st_q <= cfg_i.cont ? ST_RUN : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start_o <= 1'b0;
      standby_o    <= 1'b0;
      fresh_o      <= 1'b0;
      result_o     <= '0;
    end else begin
      conv_start_o <= tmr_load_o;
      if (latch && !cfg_i.cont) standby_o <= 1'b1;
      else if (wr_i || rd_i)    standby_o <= 1'b0;
      if (latch)     fresh_o <= 1'b1;
      else if (rd_i) fresh_o <= 1'b0;
      if (latch) result_o <= sext(conv_data_i, cfg_i.rate);
    end
  end

  AST_LATCH_MARKS_FRESH: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_WAIT) && conv_done_i && !wr_i) |=> fresh_o); // R3

  AST_READ_CLEARS_FRESH: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !((st_q == ST_WAIT) && conv_done_i && !wr_i)) |=> !fresh_o); // R4

  AST_TIMER_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    tmr_zero_i |-> (st_q == ST_RUN)); // R5

  AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> (st_q == ST_RUN)); // R6

endmodule

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
  import adc_cfg_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  parameter int RES_W      = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             host_rd,
  output logic [7:0]       cfg_rdata,
  output logic [RES_W-1:0] result_rdata,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_start,
  output logic [1:0]       gain_sel,
  output logic             standby
);

  localparam int MAX_PERIOD = BASE_TICKS * 64;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  cfg_t       cfg;
  logic       tmr_load, tmr_stop, tmr_zero, fresh;
  logic [1:0] tmr_rate;

  adc_cfg_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (host_wr),
    .wdata_i (host_wdata),
    .cfg_o   (cfg),
    .gain_o  (gain_sel)
  );

  adc_conv_timer #(
    .BASE_TICKS (BASE_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .stop_i (tmr_stop),
    .rate_i (tmr_rate),
    .zero_o (tmr_zero)
  );

  adc_conv_seq #(
    .RES_W (RES_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .wr_i         (host_wr),
    .wr_trig_i    (host_wdata[7]),
    .wr_cont_i    (host_wdata[4]),
    .wr_rate_i    (host_wdata[3:2]),
    .rd_i         (host_rd),
    .cfg_i        (cfg),
    .tmr_zero_i   (tmr_zero),
    .conv_done_i  (conv_done),
    .conv_data_i  (conv_data),
    .tmr_load_o   (tmr_load),
    .tmr_stop_o   (tmr_stop),
    .tmr_rate_o   (tmr_rate),
    .conv_start_o (conv_start),
    .standby_o    (standby),
    .fresh_o      (fresh),
    .result_o     (result_rdata)
  );

  assign cfg_rdata = {~fresh, cfg.chan, cfg.cont, cfg.rate, cfg.gain};

  AST_STANDBY_ONESHOT_ONLY: assert property (@(posedge clk) disable iff (rst)
    standby |-> !cfg.cont); // R9

endmodule

// File: tb/tb_adc_cfg_ctrl.sv
module tb_adc_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;
  localparam int RW         = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = 8'h00;
  logic          host_rd = 1'b0;
  logic [7:0]    cfg_rdata;
  logic [RW-1:0] result_rdata;
  logic          conv_done = 1'b1;
  logic [RW-1:0] conv_data = '0;
  logic          conv_start;
  logic [1:0]    gain_sel;
  logic          standby;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [RW-1:0] exp_q[$];
  logic prev_rdy = 1'b1;

  adc_cfg_ctrl #(.BASE_TICKS(BASE), .RES_W(RW)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .cfg_rdata(cfg_rdata), .result_rdata(result_rdata),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .gain_sel(gain_sel), .standby(standby)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: each fresh result is compared with the queue head.
  always @(negedge clk) begin
    if (!rst && prev_rdy && !cfg_rdata[7] && exp_q.size() > 0) begin
      logic [RW-1:0] e;
      e = exp_q.pop_front();
      check(result_rdata == e, "R3 result", result_rdata, e);
    end
    prev_rdy <= cfg_rdata[7];
  end

  task automatic do_write(input logic [7:0] b);
    @(negedge clk); host_wr = 1'b1; host_wdata = b;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  // Cycles from the current negedge until the next conv_start pulse.
  task automatic next_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!conv_start && n < 2000);
  endtask

  // Cycles from the current negedge until the freshness flag drops.
  task automatic wait_fresh(output int n);
    n = 0;
    while (cfg_rdata[7] && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic idle_no_start(input int len, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (conv_start) seen = 1'b1;
    end
  endtask

  // Single-shot conversion with known data; result goes to the scoreboard.
  task automatic oneshot(input logic [7:0] b, input logic [RW-1:0] d,
                         input logic [RW-1:0] e, input int lat, input string req);
    int n;
    conv_data = d;
    exp_q.push_back(e);
    do_write(b);
    check(conv_start == 1'b1, req, conv_start, 1);
    wait_fresh(n);
    check(n == lat, "R5 latency", n, lat);
    check(standby == 1'b1, "R9 standby set", standby, 1);
    do_read();
    check(cfg_rdata[7] == 1'b1, "R4 read clears", cfg_rdata[7], 1);
  endtask

  initial begin
    int n;
    logic seen;
    repeat (3) @(negedge clk);
    check(cfg_rdata == 8'h90, "R1 reset byte", cfg_rdata, 8'h90);
    check(standby == 1'b0, "R1 reset standby", standby, 0);
    conv_data = 18'h00123;
    rst = 1'b0;
    @(negedge clk);
    check(conv_start == 1'b1, "R1 first start", conv_start, 1);
    check(cfg_rdata[4] == 1'b1 && cfg_rdata[3:0] == 4'h0, "R2 reset fields",
          cfg_rdata[4:0], 5'h10);
    next_start(n);
    check(n == BASE + 1, "R5 rate0 spacing", n, BASE + 1);
    check(standby == 1'b0, "R9 no standby continuous", standby, 0);

    // Continuous rate 1 with bit 7 = 0: still restarts.
    do_write(8'h14);
    check(conv_start == 1'b1, "R7 restart bit7=0", conv_start, 1);
    next_start(n);
    check(n == 4 * BASE + 1, "R5 rate1 spacing", n, 4 * BASE + 1);
    do_write(8'h98);
    check(conv_start == 1'b1, "R7 restart bit7=1", conv_start, 1);
    check(cfg_rdata[6:0] == 7'h18, "R2 readback", cfg_rdata[6:0], 7'h18);
    next_start(n);
    check(n == 16 * BASE + 1, "R5 rate2 spacing", n, 16 * BASE + 1);
    do_write(8'h1C);
    next_start(n);
    check(n == 64 * BASE + 1, "R5 rate3 spacing", n, 64 * BASE + 1);

    // Single-shot without trigger: nothing starts.
    do_write(8'h00);
    do_read();
    check(cfg_rdata == 8'h80, "R2 oneshot idle byte", cfg_rdata, 8'h80);
    idle_no_start(20, seen);
    check(!seen, "R6 no trigger", seen, 0);
    check(cfg_rdata[7] == 1'b1, "R6 no result", cfg_rdata[7], 1);
    check(standby == 1'b0, "R9 write wakes", standby, 0);

    // Single-shot triggers across resolutions.
    oneshot(8'h82, 18'h00ABC, 18'h3FABC, BASE + 1, "R6 trigger");
    check(gain_sel == 2'd2, "R8 gain", gain_sel, 2);
    check(standby == 1'b0, "R9 read wakes", standby, 0);
    oneshot(8'h87, 18'h02000, 18'h3E000, 4 * BASE + 1, "R6 trigger r1");
    check(gain_sel == 2'd3, "R8 gain", gain_sel, 3);
    oneshot(8'h88, 18'h37FFF, 18'h07FFF, 16 * BASE + 1, "R6 trigger r2");
    oneshot(8'h8C, 18'h2ABCD, 18'h2ABCD, 64 * BASE + 1, "R6 trigger r3");

    // Channel bits have no effect on timing or gain.
    oneshot(8'hE1, 18'h00FFF, 18'h3FFFF, BASE + 1, "R2 channel trigger");
    check(cfg_rdata[6:5] == 2'b11 && gain_sel == 2'd1, "R2 channel readback",
          {cfg_rdata[6:5], gain_sel}, 4'hD);

    // Done wait: no latch until conv_done.
    conv_done = 1'b0;
    conv_data = 18'h00555;
    exp_q.push_back(18'h00555);
    do_write(8'h80);
    repeat (20) @(negedge clk);
    check(cfg_rdata[7] == 1'b1, "R11 held without done", cfg_rdata[7], 1);
    conv_done = 1'b1;
    @(negedge clk);
    check(cfg_rdata[7] == 1'b0, "R11 latch on done", cfg_rdata[7], 0);
    do_read();

    // Abort: long conversion interrupted by a fast one.
    conv_data = 18'h00111;
    do_write(8'h8C);
    repeat (10) @(negedge clk);
    check(cfg_rdata[7] == 1'b1, "R10 no early result", cfg_rdata[7], 1);
    conv_data = 18'h00222;
    exp_q.push_back(18'h00222);
    do_write(8'h80);
    wait_fresh(n);
    check(n == BASE + 1, "R10 restart timing", n, BASE + 1);
    do_read();
    idle_no_start(300, seen);
    check(!seen && cfg_rdata[7], "R10 single result", seen, 0);

    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule